// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does this by walking a two-level translation structure that sits in ordinary memory. A requester offers one linear address at a time. The walker first reads a directory entry, located from a root-frame input. It then reads a table entry, located from the frame that the directory entry names. The result is the table entry's frame joined to the page offset. If an entry at either level is marked absent, the walk stops and the block reports a fault. The fault carries the page-fault vector and the linear address that caused it.

A control input turns translation off. While it is low, an accepted address is returned unchanged on the next cycle and no memory read takes place. The memory side is a plain read port that allows one read in flight: the walker holds its request and address until the memory acknowledges with data. Only one translation is in progress at a time. A new one is taken only when the walker is idle.

Top module: `ptw_xlate`

## Requirements
- R1: With `pg_en` low at acceptance, the walker issues no memory read. In the cycle after acceptance, `rsp_valid`=1, `rsp_fault`=0 and `rsp_addr` equals the accepted linear address.
- R2: The first read of a walk uses the address {root[31:12], lin[31:22], 2'b00}, where root is the `dir_root` value captured at acceptance.
- R3: The second read uses the address {dir_entry[31:12], lin[21:12], 2'b00}.
- R4: A walk that finds bit 0 set in both entries responds with `rsp_fault`=0 and `rsp_addr` = {table_entry[31:12], lin[11:0]}.
- R5: If the directory entry has bit 0 clear, the walker issues no second read and reports a fault.
- R6: If the table entry has bit 0 clear, the walker reports a fault after the second read.
- R7: On a fault, `rsp_fault`=1, `rsp_vector`=14 and `rsp_addr` holds the linear address of the failed request. On success, `rsp_vector`=0.
- R8: `req_ready` is high only while idle. A `req_valid` offered during a walk is ignored: it changes neither the reads nor the response.
- R9: While `mem_req` is high and `mem_ack` has not yet arrived, `mem_req` stays high and `mem_addr` stays unchanged.
- R10: While reset is active, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0.
- R11: `rsp_valid` is a single-cycle pulse. `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_en | input | 1 | Translation enable, sampled at acceptance |
| dir_root | input | 32 | Directory root; bits 31:12 give its frame |
| req_valid | input | 1 | Linear address offered |
| req_lin | input | 32 | Linear address |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_vector | output | 8 | 14 on fault, else 0 |
| rsp_addr | output | 32 | Physical address, or faulting linear address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory read done |

## Verification
The bench builds the walker with the default index width of 10 bits. This gives the 32-bit address split (10/10/12) that the requirement formulas are written in. The bench memory is a sparse behavioural array, so directory and table entries can sit anywhere in the 4 GB space. Acknowledge latency can be set per request, from zero up to several wait cycles, which exercises the request-hold rule. Directory roots can be switched between requests, absent entries can be placed at either level, and stray requests can be injected while a walk is in progress.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_DIR   = 3'd1,
    WK_TBL   = 3'd2,
    WK_DONE  = 3'd3,
    WK_FAULT = 3'd4
  } walk_st_e;

  localparam int unsigned FAULT_VEC  = 14;
  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned ENTRY_SH   = 2;
  localparam int unsigned NUM_LVL    = 2;
endpackage

// File: rtl/ptw_slot_addr.sv
module ptw_slot_addr #(
  parameter int unsigned FRM_W = 20,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SH_W  = 2,
  localparam int unsigned OUT_W = FRM_W + IDX_W + SH_W
) (
  input  logic [FRM_W-1:0] frame,
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_W-1:0] slot_addr
);
  assign slot_addr = {frame, idx, {SH_W{1'b0}}};
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     pg_en,
  input  logic     mem_ack,
  input  logic     entry_present,
  output walk_st_e state_o,
  output logic     req_ready
);
  walk_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:  if (req_valid) state_d = pg_en ? WK_DIR : WK_DONE;
      WK_DIR:   if (mem_ack) state_d = entry_present ? WK_TBL : WK_FAULT;
      WK_TBL:   if (mem_ack) state_d = entry_present ? WK_DONE : WK_FAULT;
      WK_DONE:  state_d = WK_IDLE;
      WK_FAULT: state_d = WK_IDLE;
      default:  state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign req_ready = (state_q == WK_IDLE);

  // R9
  dir_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_DIR && !mem_ack) |=> (state_q == WK_DIR));

  // R6
  tbl_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_TBL && mem_ack && !entry_present) |=> (state_q == WK_FAULT));
endmodule

// File: rtl/ptw_xlate.sv
module ptw_xlate
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned OFF_W  = IDX_W + ENTRY_SH,
  localparam int unsigned ADDR_W = 2 * IDX_W + OFF_W,
  localparam int unsigned FRM_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_en,
  input  logic [ADDR_W-1:0] dir_root,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [7:0]        rsp_vector,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_st_e st;
  logic     accept, present;

  assign present = mem_rdata[PRESENT_BIT];

  ptw_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .pg_en         (pg_en),
    .mem_ack       (mem_ack),
    .entry_present (present),
    .state_o       (st),
    .req_ready     (req_ready)
  );

  assign accept = req_valid && req_ready;

  logic [ADDR_W-1:0] lin_q, res_q;
  logic [FRM_W-1:0]  root_q, pde_frm_q;
  logic              lin_en, pde_en, res_en;

  assign lin_en = accept;
  assign pde_en = (st == WK_DIR) && mem_ack && present;
  assign res_en = accept || ((st == WK_TBL) && mem_ack && present);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lin_q     <= '0;
      root_q    <= '0;
      pde_frm_q <= '0;
      res_q     <= '0;
    end else begin
      if (lin_en) begin
        lin_q  <= req_lin;
        root_q <= dir_root[ADDR_W-1 -: FRM_W];
      end
      if (pde_en) pde_frm_q <= mem_rdata[ADDR_W-1 -: FRM_W];
      if (res_en) res_q <= accept ? req_lin
                                  : {mem_rdata[ADDR_W-1 -: FRM_W], lin_q[OFF_W-1:0]};
    end
  end

  logic [FRM_W-1:0]  lvl_frame [NUM_LVL];
  logic [IDX_W-1:0]  lvl_idx   [NUM_LVL];
  logic [ADDR_W-1:0] lvl_addr  [NUM_LVL];

  assign lvl_frame[0] = root_q;
  assign lvl_frame[1] = pde_frm_q;

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    assign lvl_idx[lv] = lin_q[ADDR_W-1-lv*IDX_W -: IDX_W];
    ptw_slot_addr #(.FRM_W(FRM_W), .IDX_W(IDX_W), .SH_W(ENTRY_SH)) u_slot (
      .frame     (lvl_frame[lv]),
      .idx       (lvl_idx[lv]),
      .slot_addr (lvl_addr[lv])
    );
  end

  assign mem_req    = (st == WK_DIR) || (st == WK_TBL);
  assign mem_addr   = (st == WK_TBL) ? lvl_addr[1] : lvl_addr[0];
  assign rsp_valid  = (st == WK_DONE) || (st == WK_FAULT);
  assign rsp_fault  = (st == WK_FAULT);
  assign rsp_vector = rsp_fault ? 8'(FAULT_VEC) : 8'd0;
  assign rsp_addr   = rsp_fault ? lin_q : res_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R5
  dir_absent_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st == WK_DIR && mem_ack && !present) |=> (rsp_valid && rsp_fault && !mem_req));

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !pg_en) |=> (rsp_valid && !rsp_fault && rsp_addr == $past(req_lin)));

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> !req_ready);
endmodule

// File: tb/sim_ptw_xlate.sv
module sim_ptw_xlate;
  logic        clk = 1'b0;
  logic        rst_n, pg_en, req_valid, mem_ack;
  logic [31:0] dir_root, req_lin, mem_rdata;
  logic        req_ready, rsp_valid, rsp_fault, mem_req;
  logic [7:0]  rsp_vector;
  logic [31:0] rsp_addr, mem_addr;

  always #4 clk = ~clk;

  ptw_xlate u0 (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .dir_root(dir_root),
    .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
    .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_q [$];
  int  mem_lat = 0;
  int  wcnt = 0;
  bit  hold_pend = 0;
  logic [31:0] hold_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory responder, compared on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0; hold_pend = 0;
    end else begin
      if (hold_pend) begin
        chk(mem_req && mem_addr == hold_addr, "R9 hold", mem_addr, hold_addr);
      end
      hold_pend = 0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= mem_lat) begin
          mem_ack = 1'b1; mem_rdata = rd(mem_addr);
          rd_q.push_back(mem_addr); wcnt = 0;
        end else begin
          wcnt++; hold_pend = 1; hold_addr = mem_addr;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic xlate(input logic [31:0] lin, input logic en, input bit poke, input int lat, input string tag);
    logic [31:0] pde_a, pde, pte_a, pte, exp_addr;
    bit exp_fault;
    int exp_n, cyc;
    pde_a = {dir_root[31:12], lin[31:22], 2'b00};
    pde   = rd(pde_a);
    pte_a = {pde[31:12], lin[21:12], 2'b00};
    pte   = rd(pte_a);
    if (!en) begin exp_fault = 0; exp_addr = lin; exp_n = 0; end
    else if (!pde[0]) begin exp_fault = 1; exp_addr = lin; exp_n = 1; end
    else if (!pte[0]) begin exp_fault = 1; exp_addr = lin; exp_n = 2; end
    else begin exp_fault = 0; exp_addr = {pte[31:12], lin[11:0]}; exp_n = 2; end
    mem_lat = lat;
    rd_q.delete();
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R8 ready idle"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_lin = lin; pg_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 100) begin
      if (poke && cyc == 0) begin req_valid = 1'b1; req_lin = lin ^ 32'hFFC0_0000; end
      else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (!en) chk(cyc == 0, {tag, " R1 bypass latency"}, cyc, 0);
    chk(rsp_valid == 1'b1, {tag, " watchdog response"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_fault == exp_fault, {tag, " R7 fault flag"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
    chk(rsp_addr == exp_addr, {tag, " R4/R7 rsp_addr"}, rsp_addr, exp_addr);
    chk(rsp_vector == (exp_fault ? 8'd14 : 8'd0), {tag, " R7 vector"}, {24'd0, rsp_vector},
        exp_fault ? 32'd14 : 32'd0);
    chk(rd_q.size() == exp_n, {tag, " R5/R6 read count"}, rd_q.size(), exp_n);
    if (rd_q.size() >= 1) chk(rd_q[0] == pde_a, {tag, " R2 dir addr"}, rd_q[0], pde_a);
    if (rd_q.size() >= 2) chk(rd_q[1] == pte_a, {tag, " R3 tbl addr"}, rd_q[1], pte_a);
    @(negedge clk);
    chk(!rsp_valid && req_ready, {tag, " R11 pulse"}, {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pg_en = 1'b0; req_valid = 1'b0; req_lin = '0;
    dir_root = 32'h0040_0000; mem_ack = 1'b0; mem_rdata = '0;
    // directory at 0x00400000: index 0x048 -> table at 0x00800000
    mem[32'h0040_0120] = 32'h0080_0001;
    // table entries
    mem[32'h0080_0D14] = 32'hABCD_E003;   // lin idx 0x345
    mem[32'h0080_0004] = 32'h0001_2001;   // lin idx 0x001
    mem[32'h0080_0008] = 32'h5555_5000;   // lin idx 0x002, absent
    // second directory at 0x00600000: index 0x048 -> table at 0x00900000
    mem[32'h0060_0120] = 32'h0090_0001;
    mem[32'h0090_0D14] = 32'h7777_7001;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready in reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk(mem_req == 1'b0, "R10 mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    xlate(32'hDEAD_BEEF, 1'b0, 0, 0, "bypass");
    xlate(32'h1234_5678, 1'b1, 0, 0, "walk lat0");
    xlate(32'h1200_1ABC, 1'b1, 0, 3, "walk lat3");
    xlate(32'h8000_0123, 1'b1, 0, 1, "dir absent");
    xlate(32'h1200_2FFF, 1'b1, 0, 2, "tbl absent");
    xlate(32'h1234_5000, 1'b1, 1, 2, "busy poke");
    xlate(32'h8000_0123, 1'b0, 0, 0, "bypass absent");
    dir_root = 32'h0060_0ABC;
    xlate(32'h1234_5678, 1'b1, 0, 1, "root swap");
    xlate(32'h1234_5678, 1'b1, 1, 0, "root swap poke");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule